// File: doc/BRIEF.md
# Programmable Clock Divider with Lock Handshake

The block divides a reference clock by an integer ratio that software sets through one 32-bit control word. A single write port sets the output enable, a new ratio, a request to apply that ratio and a request for a downstream reset pulse. The word can be read back at any time. The read-back value also carries a lock flag, which tells software whether the divider has settled on the ratio it was last asked to apply.

A ratio written to the control word is only held as pending. It reaches the counter once software writes the apply bit, and then only at the next output period boundary, so the output never has a short pulse. The lock flag drops at once and comes back after the counter has run four whole periods at the new ratio. The divided output is given both as a clock level and as a one-cycle strobe at the start of each period, for logic that runs on the reference clock. A valid flag tells downstream logic that the output is enabled and locked. Parameters can make the low ratios illegal: an illegal code is stored as its replacement, and the read-back value shows the replacement.

Top module: `clkdiv_lock_top`

## Requirements
- R1: After reset, the read-back word has the enable bit 0, the ratio field 0 and the lock flag 1, with every other bit 0. All four outputs are low.
- R2: The enable bit is bit 0. The downstream reset request is bit 1. The apply-ratio request is bit 2. The ratio field occupies bits 4 upward, RATIO_W bits wide. Bits 1 and 2 always read back as 0. Written values show in the read-back word from the first sample after the write edge.
- R3: With SKIP = SKIP_ONE, a written ratio of 1 is stored as 0. With SKIP = SKIP_UPTO3, written ratios 1 and 2 are stored as 0 and a written 3 is stored as 4. With SKIP = SKIP_NONE, every value is stored unchanged.
- R4: A write with bit 2 set clears the lock flag from the next sample. Call n the new ratio, with 0 counted as 1, and m the previous ratio counted the same way. The lock flag returns to 1 no sooner than 4n+1 cycles and no later than m+4n cycles after the write edge.
- R5: At an applied ratio n ≥ 2, the strobe repeats every n reference cycles. The level output is high for floor(n/2) cycles of each period, starting with the strobe cycle. At ratio 0 or 1, the strobe and the level are high on every cycle.
- R6: A ratio written without bit 2 leaves the output period unchanged.
- R7: While the enable bit is 0, the level output, the strobe and the valid flag are all held low.
- R8: The valid flag is high exactly when the block is enabled and locked.
- R9: A write with bit 1 set raises the downstream reset output for exactly RST_CYCLES cycles, starting from the sample after the write edge.
- R10: The lock flag reads at bit 31 when LOCK_AT_27 is 0 and at bit 27 when it is 1. The other position reads 0.
- R11: The all-ones ratio is legal. It divides by 2^RATIO_W − 1, with a high phase one cycle shorter than the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read-back |
| div_clk | output | 1 | Divided clock level |
| div_tick | output | 1 | One-cycle strobe at each output period start |
| out_valid | output | 1 | Output enabled and locked |
| dom_rst | output | 1 | Reset pulse for the downstream domain |

## Verification
The read-back word, the gated outputs, the valid flag and the first cycle of the reset pulse all change on the write edge itself. The bench therefore queues its expected values at the falling edge that follows each write, and a monitor compares them two nanoseconds later. The lock return depends on where the old period happens to be, so the bench counts cycles from the write to the first sample showing lock and checks that the count falls inside the R4 window. It does not check for one exact cycle. Period and high-phase lengths are measured from one strobe to the next once the block has locked, and the reset pulse is measured by counting consecutive high samples.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int EN_POS    = 0;
  localparam int RSTREQ_POS = 1;
  localparam int APPLY_POS = 2;
  localparam int RATIO_LSB = 4;
  localparam int LOCK_POS_HI = 31;
  localparam int LOCK_POS_LO = 27;

  typedef enum logic [1:0] {
    SKIP_NONE  = 2'd0,
    SKIP_ONE   = 2'd1,
    SKIP_UPTO3 = 2'd2
  } skip_e;

  // Replacement code for ratios made illegal by the skip option.
  function automatic logic [31:0] remap_ratio(input logic [31:0] v, input skip_e mode);
    logic [31:0] r;
    r = v;
    case (mode)
      SKIP_ONE:   if (v == 32'd1) r = 32'd0;
      SKIP_UPTO3: begin
        if (v == 32'd1 || v == 32'd2) r = 32'd0;
        else if (v == 32'd3)          r = 32'd4;
      end
      default: r = v;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int RATIO_W = 8,
  parameter clkdiv_pkg::skip_e SKIP = clkdiv_pkg::SKIP_NONE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_cmd,
  input  logic [RATIO_W-1:0] wr_ratio,
  output logic               en_q,
  output logic               en_nx,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               apply_req,
  output logic               rst_req
);
  logic [RATIO_W-1:0] mapped;

  always_comb begin
    en_nx     = wr_en ? wr_cmd[clkdiv_pkg::EN_POS] : en_q;
    apply_req = wr_en & wr_cmd[clkdiv_pkg::APPLY_POS];
    rst_req   = wr_en & wr_cmd[clkdiv_pkg::RSTREQ_POS];
    mapped    = RATIO_W'(clkdiv_pkg::remap_ratio(32'(wr_ratio), SKIP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ratio_q <= '0;
    end else begin
      en_q <= en_nx;
      if (wr_en) ratio_q <= mapped;
    end
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int RATIO_W = 8,
  parameter int LOCK_PERIODS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_nx,
  input  logic [RATIO_W-1:0] ratio_pend,
  input  logic               apply_req,
  output logic               locked,
  output logic               div_clk,
  output logic               div_tick,
  output logic               out_valid
);
  localparam int PW = $clog2(LOCK_PERIODS + 1);

  logic [RATIO_W-1:0] act_q, act_nx, cnt_q, cnt_nx, n_cur, n_nx, half_nx;
  logic               pend_q, pend_nx, lock_q, lock_nx, boundary, phase_hi;
  logic [PW-1:0]      per_q, per_nx;

  always_comb begin
    n_cur    = (act_q == '0) ? RATIO_W'(1) : act_q;
    boundary = (cnt_q == n_cur - RATIO_W'(1));
    act_nx   = act_q;
    cnt_nx   = cnt_q + RATIO_W'(1);
    pend_nx  = pend_q;
    lock_nx  = lock_q;
    per_nx   = per_q;
    if (boundary) begin
      cnt_nx = '0;
      if (pend_q) begin
        act_nx  = ratio_pend;
        pend_nx = 1'b0;
        per_nx  = '0;
      end else if (!lock_q) begin
        if (per_q == PW'(LOCK_PERIODS - 1)) lock_nx = 1'b1;
        else                                 per_nx  = per_q + PW'(1);
      end
    end
    if (apply_req) begin
      pend_nx = 1'b1;
      lock_nx = 1'b0;
    end
    n_nx     = (act_nx == '0) ? RATIO_W'(1) : act_nx;
    half_nx  = n_nx >> 1;
    phase_hi = (n_nx == RATIO_W'(1)) || (cnt_nx < half_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      lock_q    <= 1'b1;
      per_q     <= '0;
      div_clk   <= 1'b0;
      div_tick  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      act_q     <= act_nx;
      cnt_q     <= cnt_nx;
      pend_q    <= pend_nx;
      lock_q    <= lock_nx;
      per_q     <= per_nx;
      div_clk   <= en_nx & phase_hi;
      div_tick  <= en_nx & (cnt_nx == '0);
      out_valid <= en_nx & lock_nx;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/clkdiv_rstgen.sv
module clkdiv_rstgen #(
  parameter int RST_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic dom_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (req)              cnt_nx = CW'(RST_CYCLES);
    else if (cnt_q != '0) cnt_nx = cnt_q - CW'(1);
    else                  cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dom_rst <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      dom_rst <= (cnt_nx != '0);
    end
  end
endmodule

// File: rtl/clkdiv_lock_top.sv
module clkdiv_lock_top #(
  parameter int RATIO_W = 8,
  parameter bit LOCK_AT_27 = 1'b0,
  parameter clkdiv_pkg::skip_e SKIP = clkdiv_pkg::SKIP_NONE,
  parameter int RST_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        div_clk,
  output logic        div_tick,
  output logic        out_valid,
  output logic        dom_rst
);
  localparam int LOCK_POS = LOCK_AT_27 ? clkdiv_pkg::LOCK_POS_LO : clkdiv_pkg::LOCK_POS_HI;

  logic               en_q, en_nx, apply_req, rst_req, locked;
  logic [RATIO_W-1:0] ratio_q;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[3], wr_data[31:clkdiv_pkg::RATIO_LSB+RATIO_W]};

  clkdiv_regs #(.RATIO_W(RATIO_W), .SKIP(SKIP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_cmd(wr_data[2:0]),
    .wr_ratio(wr_data[clkdiv_pkg::RATIO_LSB +: RATIO_W]),
    .en_q(en_q), .en_nx(en_nx), .ratio_q(ratio_q),
    .apply_req(apply_req), .rst_req(rst_req)
  );

  clkdiv_core #(.RATIO_W(RATIO_W), .LOCK_PERIODS(4)) u_core (
    .clk(clk), .rst(rst), .en_nx(en_nx), .ratio_pend(ratio_q),
    .apply_req(apply_req), .locked(locked),
    .div_clk(div_clk), .div_tick(div_tick), .out_valid(out_valid)
  );

  clkdiv_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
    .clk(clk), .rst(rst), .req(rst_req), .dom_rst(dom_rst)
  );

  // Read-back assembly; the lock flag position is chosen at build time.
  generate
    if (LOCK_AT_27) begin : g_lock_lo
      always_comb begin
        rd_data = '0;
        rd_data[clkdiv_pkg::EN_POS] = en_q;
        rd_data[clkdiv_pkg::RATIO_LSB +: RATIO_W] = ratio_q;
        rd_data[clkdiv_pkg::LOCK_POS_LO] = locked;
      end
    end else begin : g_lock_hi
      always_comb begin
        rd_data = '0;
        rd_data[clkdiv_pkg::EN_POS] = en_q;
        rd_data[clkdiv_pkg::RATIO_LSB +: RATIO_W] = ratio_q;
        rd_data[clkdiv_pkg::LOCK_POS_HI] = locked;
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_lock_chk.sv
module clkdiv_lock_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         apply_bit,
  input logic         rstreq_bit,
  input logic         en_bit,
  input logic         lock_bit,
  input logic [W-1:0] ratio,
  input logic         div_clk,
  input logic         div_tick,
  input logic         out_valid,
  input logic         dom_rst
);
  assert_lock_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && apply_bit) |=> !lock_bit);

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rstreq_bit) |=> dom_rst);

  assert_gated_low_R7: assert property (@(posedge clk) disable iff (rst)
    !en_bit |-> (!div_clk && !div_tick && !out_valid));

  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ratio));

  assert_tick_in_high_R5: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> div_clk);

  assert_valid_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (en_bit && lock_bit));
endmodule

bind clkdiv_lock_top clkdiv_lock_chk #(.W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en),
  .apply_bit(wr_data[2]), .rstreq_bit(wr_data[1]),
  .en_bit(rd_data[0]), .lock_bit(rd_data[LOCK_POS]),
  .ratio(rd_data[4 +: RATIO_W]),
  .div_clk(div_clk), .div_tick(div_tick), .out_valid(out_valid), .dom_rst(dom_rst)
);

// File: tb/clkdiv_lock_top_tb.sv
`timescale 1ns/1ps
module clkdiv_lock_top_tb;
  localparam int RST_CYC = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, rd1, rd3;
  logic c0, t0, v0, r0, c1, t1, v1, r1, c3, t3, v3, r3;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_lock_top u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd0), .div_clk(c0), .div_tick(t0), .out_valid(v0), .dom_rst(r0));
  clkdiv_lock_top #(.SKIP(clkdiv_pkg::SKIP_ONE)) u_dut_s1 (.clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd1), .div_clk(c1), .div_tick(t1), .out_valid(v1), .dom_rst(r1));
  clkdiv_lock_top #(.SKIP(clkdiv_pkg::SKIP_UPTO3), .LOCK_AT_27(1'b1)) u_dut_s3 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd3), .div_clk(c3), .div_tick(t3), .out_valid(v3), .dom_rst(r3));

  typedef struct {
    int          sel;
    logic [35:0] mask;
    logic [35:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  function automatic logic [35:0] obs(int sel);
    case (sel)
      1:       return {rd1, c1, t1, v1, r1};
      3:       return {rd3, c3, t3, v3, r3};
      default: return {rd0, c0, t0, v0, r0};
    endcase
  endfunction

  // Monitor: compares every queued expectation slightly after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [35:0] got;
        it  = sbq.pop_front();
        got = obs(it.sel) & it.mask;
        checks++;
        if (got !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s inst%0d actual %h expected %h", it.tag, it.sel, got, it.exp & it.mask);
        end
      end
    end
  end

  task automatic push(int sel, logic [35:0] mask, logic [35:0] exp, string tag);
    item_t it;
    it.sel = sel; it.mask = mask; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_rd(int sel, logic [31:0] v, string tag);
    push(sel, {32'hFFFF_FFFF, 4'h0}, {v, 4'h0}, tag);
  endtask

  task automatic exp_out(int sel, logic [3:0] v, string tag);
    push(sel, 36'hF, {32'h0, v}, tag);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // All driver tasks start and end on a falling edge.
  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic apply_ratio(int r, int n_old);
    int n, m, k;
    n = (r == 0) ? 1 : r;
    m = (n_old == 0) ? 1 : n_old;
    wr(32'(1 | 4 | (r << 4)));
    push(0, {32'h8000_0000, 4'h0}, 36'h0, "R4 lock drop");
    push(0, {32'h0000_0006, 4'h0}, 36'h0, "R2 self-clear");
    push(3, {32'h0800_0000, 4'h0}, 36'h0, "R10 lock drop at 27");
    k = 0;
    while (!rd0[31] && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k >= 4*n+1 && k <= m + 4*n, "R4 lock window", k, 4*n+1);
  endtask

  task automatic measure(int r, string tag);
    int n, d, hi, g;
    n = (r == 0) ? 1 : r;
    if (n == 1) begin
      for (int i = 0; i < 6; i++) begin
        chk(c0 && t0, tag, {c0, t0}, 3);
        @(negedge clk);
      end
    end else begin
      g = 0;
      while (!t0 && g < 1000) begin @(negedge clk); g++; end
      d = 0; hi = 0;
      do begin
        if (c0) hi++;
        d++;
        @(negedge clk);
      end while (!t0 && d < 1000);
      chk(d == n, {tag, " period"}, d, n);
      chk(hi == n/2, {tag, " high phase"}, hi, n/2);
    end
  endtask

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R10 lock position
    exp_rd(0, 32'h8000_0000, "R1 reset word");
    exp_out(0, 4'h0, "R1 reset outputs");
    exp_rd(3, 32'h0800_0000, "R10 lock at bit 27");
    @(negedge clk);

    // R2 layout; no apply, so still dividing by one (R6, R8)
    wr(32'h0000_0041);
    exp_rd(0, 32'h8000_0041, "R2 readback");
    exp_out(0, 4'b1110, "R8 valid with lock");
    @(negedge clk);
    measure(0, "R6 unapplied ratio");

    apply_ratio(4, 0);
    measure(4, "R5 even ratio");

    wr(32'h0000_0071);
    measure(4, "R6 pending ratio ignored");
    apply_ratio(7, 4);
    measure(7, "R5 odd ratio");

    apply_ratio(0, 7);
    measure(0, "R5 ratio zero");

    // R7 gating
    wr(32'h0000_0000);
    exp_out(0, 4'h0, "R7 gated");
    @(negedge clk);
    @(negedge clk);
    exp_out(0, 4'h0, "R7 gated hold");
    @(negedge clk);

    // R3 remapping across skip options
    wr(32'h0000_0010);
    exp_rd(0, 32'h8000_0010, "R3 none 1");
    exp_rd(1, 32'h8000_0000, "R3 skip1 1");
    exp_rd(3, 32'h0800_0000, "R3 skip3 1");
    @(negedge clk);
    wr(32'h0000_0020);
    exp_rd(1, 32'h8000_0020, "R3 skip1 2");
    exp_rd(3, 32'h0800_0000, "R3 skip3 2");
    @(negedge clk);
    wr(32'h0000_0030);
    exp_rd(1, 32'h8000_0030, "R3 skip1 3");
    exp_rd(3, 32'h0800_0040, "R3 skip3 3");
    @(negedge clk);

    // R9 downstream reset pulse
    wr(32'h0000_0002);
    push(0, {32'h0000_0002, 4'h0}, 36'h0, "R2 reset bit self-clear");
    c = 0;
    while (r0 && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk(c == RST_CYC, "R9 pulse length", c, RST_CYC);

    // R11 largest ratio, R10 lock position after relock
    apply_ratio(255, 0);
    measure(255, "R11 max ratio");
    chk(rd3[27] && !rd3[31], "R10 relock at 27", {rd3[31], rd3[27]}, 1);
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule